// File: doc/BRIEF.md
# Change-Triggered Parallel-to-SPI Serializer

This block is an SPI master that turns a parallel word into a serial frame. Every system clock it captures a bank of input pins into a pin register. A configuration bit picks either that captured word or a word that the host writes into an alternate data register. The chosen word is shifted out most significant bit first on a divided clock, and a set of active-low peripheral selects frames the transfer. The frame is 16 bits wide by default and 32 bits wide in the wide mode.

Transfers start in one of two ways. With change detection enabled, the block keeps the last word it sent and starts a new frame as soon as the selected word differs from it. With change detection off, the host writes a one-cycle start strobe. A per-line mask chooses which selects are asserted. In wide mode a second mask drives the selects for the upper 16 bits. A hold option keeps the selects asserted between frames. A 3-bit attribute selector is sampled at frame start and presented on a port for the whole frame.

The controller has three states. `ST_IDLE` moves to `ST_SHIFT` when a start is raised. `ST_SHIFT` runs the bit clock and moves on after the falling edge of the last bit: to `ST_IDLE` when hold is set, otherwise to `ST_TAIL`. `ST_TAIL` keeps the selects asserted for half a bit period, then releases them and returns to `ST_IDLE`.

Top module: `chg_spi_serializer`

## Requirements
- R1: While reset is active and right after it, `cs_n_o` is all ones, and `sck_o`, `mosi_o` and `busy_o` are 0.
- R2: `pins_i` is captured into the pin register on every rising clock edge. A read at host address 3 returns the pin value from the previous edge.
- R3: Config bit 0 (address 0) chooses the data source: 0 selects the pin register and 1 selects the alternate register (address 2). Changes in the source that is not selected start no frame.
- R4: With change detection on (config bit 1), a frame starts only when the selected word, within the frame width, differs from the last word sent. Rewriting the same word starts no frame.
- R5: The last-sent register is cleared by reset and loaded with the frame word when the last bit completes. A change made during a frame starts the next frame once this frame has ended.
- R6: `sck_o` idles low and has a period of CLK_DIV system clocks. `mosi_o` presents the word MSB first and changes only while `sck_o` is low.
- R7: The select mask (config bits 11:8, bit n for line n) asserts `cs_n_o[n]` low for each 1 and keeps it high for each 0 during the frame.
- R8: Config bit 3 selects 32-bit frames. In that mode bits 16..31 of the frame use the upper mask (address 1) and change detection covers all 32 bits. In 16-bit mode only the low 16 bits are sent and compared.
- R9: With hold (config bit 2) set, the selects stay asserted after the frame. Clearing hold while idle releases them. With hold clear, they are released after a half-bit tail.
- R10: `attr_sel_o` shows config bits 6:4 as sampled at frame start (eight values, 0 to 7), and the value applies to the whole frame.
- R11: `busy_o` rises one cycle after a start condition. It falls when the selects are released, or at the last bit's falling edge in hold mode.
- R12: With change detection off, writing config bit 7 as 1 (a self-clearing strobe) starts one frame. With no strobe, no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | FRAME_W | Parallel input pins |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | FRAME_W | Host write data |
| host_rdata_o | output | FRAME_W | Host read data for the current address |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | NUM_CS | Active-low peripheral selects |
| busy_o | output | 1 | Frame in progress |
| attr_sel_o | output | 3 | Attribute set selected for the current frame |

## Verification
The assertions assume that the start strobe is written only while the block is idle, because a strobe that arrives during a frame is dropped. They also assume that configuration is changed only between frames, so that the sampled hold and mask values match the live ones. The bench waits for `busy_o` to fall before every configuration or strobe write. Data changes are the only writes it makes during a frame, and they are exactly the changes that must queue behind the frame in progress.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } ser_state_e;

    typedef struct packed {
        logic       alt_src;
        logic       chg_en;
        logic       hold;
        logic       wide;
        logic [2:0] attr;
    } ser_cfg_t;

endpackage

// File: rtl/ser_regs.sv
module ser_regs
    import ser_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int NUM_CS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         addr_i,
    input  logic [FRAME_W-1:0] wdata_i,
    input  logic [FRAME_W-1:0] pins_i,
    output logic [FRAME_W-1:0] rdata_o,
    output ser_cfg_t           cfg_o,
    output logic [NUM_CS-1:0]  mask_lo_o,
    output logic [NUM_CS-1:0]  mask_hi_o,
    output logic [FRAME_W-1:0] alt_o,
    output logic [FRAME_W-1:0] pin_q_o,
    output logic               go_o
);

    localparam int MASK_LSB = 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q_o   <= '0;
            cfg_o     <= '0;
            mask_lo_o <= '0;
            mask_hi_o <= '0;
            alt_o     <= '0;
            go_o      <= 1'b0;
        end else begin
            pin_q_o <= pins_i;
            go_o    <= wr_i && (addr_i == 2'd0) && wdata_i[7];
            if (wr_i) begin
                unique case (addr_i)
                    2'd0: begin
                        cfg_o.alt_src <= wdata_i[0];
                        cfg_o.chg_en  <= wdata_i[1];
                        cfg_o.hold    <= wdata_i[2];
                        cfg_o.wide    <= wdata_i[3];
                        cfg_o.attr    <= wdata_i[6:4];
                        mask_lo_o     <= wdata_i[MASK_LSB +: NUM_CS];
                    end
                    2'd1:    mask_hi_o <= wdata_i[NUM_CS-1:0];
                    2'd2:    alt_o     <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            2'd0: begin
                rdata_o[0]                   = cfg_o.alt_src;
                rdata_o[1]                   = cfg_o.chg_en;
                rdata_o[2]                   = cfg_o.hold;
                rdata_o[3]                   = cfg_o.wide;
                rdata_o[6:4]                 = cfg_o.attr;
                rdata_o[MASK_LSB +: NUM_CS]  = mask_lo_o;
            end
            2'd1:    rdata_o[NUM_CS-1:0] = mask_hi_o;
            2'd2:    rdata_o = alt_o;
            default: rdata_o = pin_q_o;
        endcase
    end

endmodule

// File: rtl/ser_trigger.sv
module ser_trigger #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alt_src_i,
    input  logic               chg_en_i,
    input  logic               wide_i,
    input  logic               go_i,
    input  logic               idle_i,
    input  logic               done_i,
    input  logic [FRAME_W-1:0] pin_i,
    input  logic [FRAME_W-1:0] alt_i,
    input  logic [FRAME_W-1:0] tx_word_i,
    output logic               start_o,
    output logic [FRAME_W-1:0] word_o
);

    localparam int HALF_W = FRAME_W / 2;

    logic [FRAME_W-1:0] cmp_q;
    logic [FRAME_W-1:0] fmask;
    logic               differ;

    always_comb begin
        word_o  = alt_src_i ? alt_i : pin_i;
        fmask   = wide_i ? {FRAME_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        differ  = ((word_o ^ cmp_q) & fmask) != '0;
        start_o = idle_i && (go_i || (chg_en_i && differ));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (done_i) cmp_q <= tx_word_i;
    end

    // R5
    cmp_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_q) |-> $past(done_i));

endmodule

// File: rtl/ser_engine.sv
module ser_engine
    import ser_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int NUM_CS  = 4,
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] word_i,
    input  logic               wide_i,
    input  logic               hold_i,
    input  logic [2:0]         attr_i,
    input  logic [NUM_CS-1:0]  mask_lo_i,
    input  logic [NUM_CS-1:0]  mask_hi_i,
    output logic               sck_o,
    output logic               mosi_o,
    output logic [NUM_CS-1:0]  cs_n_o,
    output logic               busy_o,
    output logic [2:0]         attr_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] tx_word_o
);

    localparam int HALF_W   = FRAME_W / 2;
    localparam int HALF_CLK = CLK_DIV / 2;
    localparam int CW       = (HALF_CLK > 1) ? $clog2(HALF_CLK) : 1;
    localparam int BW       = $clog2(FRAME_W);

    ser_state_e         state, nxt;
    logic               phase;
    logic [CW-1:0]      cnt;
    logic [BW-1:0]      bit_idx;
    logic [BW-1:0]      last_idx;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame_q;
    logic [NUM_CS-1:0]  cs_act;
    logic [NUM_CS-1:0]  mask_hi_q;
    logic               wide_q, hold_q;
    logic [2:0]         attr_q;
    logic               tick, fall_evt, last_bit;

    always_comb begin
        tick     = (cnt == '0);
        last_idx = wide_q ? BW'(FRAME_W - 1) : BW'(HALF_W - 1);
        fall_evt = (state == ST_SHIFT) && phase && tick;
        last_bit = fall_evt && (bit_idx == last_idx);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i)  nxt = ST_SHIFT;
            ST_SHIFT: if (last_bit) nxt = hold_q ? ST_IDLE : ST_TAIL;
            ST_TAIL:  if (tick)     nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            frame_q   <= '0;
            cs_act    <= '0;
            mask_hi_q <= '0;
            wide_q    <= 1'b0;
            hold_q    <= 1'b0;
            attr_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        phase     <= 1'b0;
                        cnt       <= CW'(HALF_CLK - 1);
                        bit_idx   <= '0;
                        shreg     <= wide_i ? word_i
                                            : {word_i[HALF_W-1:0], {HALF_W{1'b0}}};
                        frame_q   <= wide_i ? word_i
                                            : {{HALF_W{1'b0}}, word_i[HALF_W-1:0]};
                        cs_act    <= mask_lo_i;
                        mask_hi_q <= mask_hi_i;
                        wide_q    <= wide_i;
                        hold_q    <= hold_i;
                        attr_q    <= attr_i;
                    end else if (!hold_i) begin
                        cs_act <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        cnt <= CW'(HALF_CLK - 1);
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            if (bit_idx != last_idx) begin
                                bit_idx <= bit_idx + 1'b1;
                                shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                                if (bit_idx == BW'(HALF_W - 1)) cs_act <= mask_hi_q;
                            end
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (tick) cs_act <= '0;
                    else      cnt    <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sck_o     = (state == ST_SHIFT) && phase;
        mosi_o    = shreg[FRAME_W-1];
        cs_n_o    = ~cs_act;
        busy_o    = (state != ST_IDLE);
        attr_o    = attr_q;
        done_o    = last_bit;
        tx_word_o = frame_q;
    end

    // R6
    sck_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> busy_o);

    // R6
    mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R9
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !hold_i && !start_i) |=> (cs_n_o == {NUM_CS{1'b1}}));

    // R8
    narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wide_q) |-> (bit_idx < BW'(HALF_W)));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/chg_spi_serializer.sv
module chg_spi_serializer
    import ser_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int NUM_CS  = 4,
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] pins_i,
    input  logic               host_wr_i,
    input  logic [1:0]         host_addr_i,
    input  logic [FRAME_W-1:0] host_wdata_i,
    output logic [FRAME_W-1:0] host_rdata_o,
    output logic               sck_o,
    output logic               mosi_o,
    output logic [NUM_CS-1:0]  cs_n_o,
    output logic               busy_o,
    output logic [2:0]         attr_sel_o
);

    ser_cfg_t           cfg;
    logic [NUM_CS-1:0]  mask_lo, mask_hi;
    logic [FRAME_W-1:0] alt_word, pin_word, sel_word, tx_word;
    logic               go, start, done;

    ser_regs #(.FRAME_W(FRAME_W), .NUM_CS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (host_wr_i),
        .addr_i    (host_addr_i),
        .wdata_i   (host_wdata_i),
        .pins_i    (pins_i),
        .rdata_o   (host_rdata_o),
        .cfg_o     (cfg),
        .mask_lo_o (mask_lo),
        .mask_hi_o (mask_hi),
        .alt_o     (alt_word),
        .pin_q_o   (pin_word),
        .go_o      (go)
    );

    ser_trigger #(.FRAME_W(FRAME_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .alt_src_i (cfg.alt_src),
        .chg_en_i  (cfg.chg_en),
        .wide_i    (cfg.wide),
        .go_i      (go),
        .idle_i    (!busy_o),
        .done_i    (done),
        .pin_i     (pin_word),
        .alt_i     (alt_word),
        .tx_word_i (tx_word),
        .start_o   (start),
        .word_o    (sel_word)
    );

    ser_engine #(.FRAME_W(FRAME_W), .NUM_CS(NUM_CS), .CLK_DIV(CLK_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .word_i    (sel_word),
        .wide_i    (cfg.wide),
        .hold_i    (cfg.hold),
        .attr_i    (cfg.attr),
        .mask_lo_i (mask_lo),
        .mask_hi_i (mask_hi),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .cs_n_o    (cs_n_o),
        .busy_o    (busy_o),
        .attr_o    (attr_sel_o),
        .done_o    (done),
        .tx_word_o (tx_word)
    );

endmodule

// File: tb/tb_chg_spi_serializer.sv
module tb_chg_spi_serializer;

    localparam int NCS = 4;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, busy;
    logic [3:0]  cs_n;
    logic [2:0]  attr_sel;

    always #2 clk = ~clk;

    chg_spi_serializer #(.FRAME_W(32), .NUM_CS(NCS), .CLK_DIV(DIV)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .host_wr_i    (wr),
        .host_addr_i  (addr),
        .host_wdata_i (wdata),
        .host_rdata_o (rdata),
        .sck_o        (sck),
        .mosi_o       (mosi),
        .cs_n_o       (cs_n),
        .busy_o       (busy),
        .attr_sel_o   (attr_sel)
    );

    int checks = 0;
    int fails  = 0;

    logic        prev_sck = 1'b0, prev_busy = 1'b0, prev_mosi = 1'b0;
    logic [31:0] rx = '0;
    int          nbits = 0, frames = 0, since_rise = 0, last_period = 0, mosi_viol = 0;
    logic [3:0]  cs_first = '1, cs_last = '1;

    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            frames = frames + 1;
            nbits  = 0;
            rx     = '0;
        end
        since_rise = since_rise + 1;
        if (sck && !prev_sck) begin
            rx = {rx[30:0], mosi};
            if (nbits == 0) cs_first = cs_n;
            else            last_period = since_rise;
            cs_last    = cs_n;
            since_rise = 0;
            nbits      = nbits + 1;
        end
        if (sck && prev_sck && (mosi !== prev_mosi)) mosi_viol = mosi_viol + 1;
        prev_sck  = sck;
        prev_busy = busy;
        prev_mosi = mosi;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(input bit alt, input bit chg, input bit hold,
                                         input bit wide, input logic [2:0] at,
                                         input bit go, input logic [3:0] mlo);
        return {20'b0, mlo, go, at, wide, hold, chg, alt};
    endfunction

    task automatic expect_frame(input logic [31:0] w, input int bits, input logic [3:0] mfirst,
                                input logic [3:0] mlast, input logic [2:0] at, input bit hold,
                                input string tag);
        int t = 0;
        while (!busy && t < 2000) begin @(negedge clk); t++; end
        chk(busy, {tag, " frame started"}, {31'b0, busy}, 32'd1);
        while (busy && t < 4000) begin @(negedge clk); t++; end
        chk(nbits == bits, {tag, " bit count"}, nbits, bits);
        chk(rx == w, {tag, " word MSB first"}, rx, w);
        chk(cs_first == ~mfirst, {tag, " R7 select mask first bit"}, {28'b0, cs_first}, {28'b0, ~mfirst});
        chk(cs_last == ~mlast, {tag, " R8 select mask last bit"}, {28'b0, cs_last}, {28'b0, ~mlast});
        chk(attr_sel == at, {tag, " R10 attribute"}, {29'b0, attr_sel}, {29'b0, at});
        if (!hold) chk(cs_n == 4'hF, {tag, " R11 busy until release"}, {28'b0, cs_n}, 32'hF);
        else       chk(cs_n == ~mlast, {tag, " R9 held at end"}, {28'b0, cs_n}, {28'b0, ~mlast});
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        int f0 = frames;
        repeat (cycles) @(negedge clk);
        chk((frames == f0) && !busy, tag, frames - f0, 0);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cs_n == 4'hF, "R1 cs_n in reset", {28'b0, cs_n}, 32'hF);
        chk(!sck && !mosi && !busy, "R1 sck/mosi/busy in reset", {29'b0, sck, mosi, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF && !sck && !busy, "R1 after reset", {28'b0, cs_n}, 32'hF);

        // R2 pin capture readback
        pins = 32'hA5C3_1234;
        @(negedge clk);
        addr = 2'd3;
        #1;
        chk(rdata == 32'hA5C3_1234, "R2 pin register", rdata, 32'hA5C3_1234);

        // R12 strobe start
        hw(2'd2, 32'h0000_BEEF);
        expect_quiet(40, "R12 no frame without strobe");
        hw(2'd0, cfgw(1, 0, 0, 0, 3'd5, 1, 4'b0101));
        @(negedge clk);
        chk(busy, "R11 busy one cycle after strobe", {31'b0, busy}, 1);
        expect_frame(32'h0000_BEEF, 16, 4'b0101, 4'b0101, 3'd5, 0, "R12 R6");

        // R4 change-detect sweep over masks and attributes
        for (int i = 0; i < 8; i++) begin
            hw(2'd0, cfgw(1, 1, 0, 0, 3'(i), 0, 4'(i + 1)));
            expect_quiet(12, "R4 config write alone");
            v = 16'((i + 1) * 16'h2345);
            hw(2'd2, {16'h0, v});
            expect_frame({16'h0, v}, 16, 4'(i + 1), 4'(i + 1), 3'(i), 0, "R4 R7 R10");
            hw(2'd2, {16'h0, v});
            expect_quiet(40, "R4 same word rewritten");
        end
        hw(2'd2, {16'hFFFF, v});
        expect_quiet(40, "R8 upper half ignored in 16-bit mode");

        // R3 pin source
        pins = {16'h0, v};
        hw(2'd0, cfgw(0, 1, 0, 0, 3'd2, 0, 4'b1001));
        expect_quiet(20, "R3 pins equal last word");
        pins = 32'h0000_5A5A;
        expect_frame(32'h0000_5A5A, 16, 4'b1001, 4'b1001, 3'd2, 0, "R3 pins");
        hw(2'd2, 32'h0000_1357);
        expect_quiet(40, "R3 alternate ignored while pins selected");
        pins = 32'h0000_3C3C;
        expect_frame(32'h0000_3C3C, 16, 4'b1001, 4'b1001, 3'd2, 0, "R3 pins second");

        // R3 switch to alternate source starts a frame with its word
        hw(2'd0, cfgw(1, 1, 0, 0, 3'd1, 0, 4'b0110));
        expect_frame(32'h0000_1357, 16, 4'b0110, 4'b0110, 3'd1, 0, "R3 alternate");

        // R5 change during a frame queues behind it
        hw(2'd2, 32'h0000_C001);
        while (!busy) @(negedge clk);
        hw(2'd2, 32'h0000_0FF0);
        expect_frame(32'h0000_C001, 16, 4'b0110, 4'b0110, 3'd1, 0, "R5 first");
        expect_frame(32'h0000_0FF0, 16, 4'b0110, 4'b0110, 3'd1, 0, "R5 queued");
        expect_quiet(30, "R5 no repeat after update");

        // R8 wide frames
        hw(2'd1, 32'h0000_0008);
        hw(2'd0, cfgw(1, 1, 0, 1, 3'd6, 0, 4'b0001));
        expect_quiet(20, "R8 mode switch same word");
        hw(2'd2, 32'h1234_5678);
        expect_frame(32'h1234_5678, 32, 4'b0001, 4'b1000, 3'd6, 0, "R8 wide");
        hw(2'd2, 32'h9234_5678);
        expect_frame(32'h9234_5678, 32, 4'b0001, 4'b1000, 3'd6, 0, "R8 upper change");

        // R9 hold selects
        hw(2'd0, cfgw(1, 1, 1, 0, 3'd7, 0, 4'b0011));
        expect_quiet(20, "R8 narrow compare low half only");
        hw(2'd2, 32'h0000_ABCD);
        expect_frame(32'h0000_ABCD, 16, 4'b0011, 4'b0011, 3'd7, 1, "R9 hold");
        repeat (20) @(negedge clk);
        chk(cs_n == 4'b1100, "R9 selects held while idle", {28'b0, cs_n}, 32'hC);
        chk(!busy, "R11 busy low in hold idle", {31'b0, busy}, 0);
        hw(2'd0, cfgw(1, 1, 0, 0, 3'd7, 0, 4'b0011));
        @(negedge clk);
        chk(cs_n == 4'hF, "R9 release on hold clear", {28'b0, cs_n}, 32'hF);

        // R6 clock period and data stability
        chk(last_period == DIV, "R6 sck period", last_period, DIV);
        chk(mosi_viol == 0, "R6 mosi stable while sck high", mosi_viol, 0);
        chk(!sck, "R6 sck idles low", {31'b0, sck}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule